// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block forms an effective memory address from four parts: a base register value, an index register value shifted left by a small scale, and a signed immediate offset. Either register operand may be marked absent, in which case its term contributes nothing. A mode input selects between a full 64-bit address and a narrow 32-bit address. The block only produces the address; it never reads or writes memory, just as a load-effective-address operation yields a pointer and stops there.

The sum is computed combinationally and, in the default build, captured in one output register together with a valid flag. The output stage is a two-state machine. `OUT_IDLE` means no address is presented. `OUT_LIVE` means the address register holds a freshly computed result. From either state, the machine moves to `OUT_LIVE` on a clock edge where `in_vld` is high, and to `OUT_IDLE` on an edge where it is low. Synchronous reset forces `OUT_IDLE`. When a cycle carries no valid request, the address register keeps its previous value.

Top module: `agu_addr_gen`

## Requirements
- R1: In 64-bit mode (`mode32`=0), `ea` equals base + (index shifted left by the scale) + sign-extended displacement, taken modulo 2^64.
- R2: `scale_sel` encodes the index multiplier: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8. This is a left shift by 0 to 3 bits.
- R3: When `base_en` is 0, the base term is zero, whatever value is on `base_val`.
- R4: When `idx_en` is 0, the index term is zero, whatever value is on `idx_val` or `scale_sel`.
- R5: `disp` is a 32-bit two's-complement value. Bit 31 is copied into bits 63..32 before the addition.
- R6: In 32-bit mode (`mode32`=1), only bits 31..0 of base and index are used. The sum is cut to 32 bits and `ea[63:32]` is zero.
- R7: `ea_vld` is high exactly one clock after a cycle with `in_vld` high, and low one clock after a cycle with `in_vld` low. The `ea` shown with it belongs to the operands of that earlier cycle.
- R8: After synchronous reset, `ea_vld` is 0 and `ea` is 0.
- R9: After a cycle with `in_vld` low, `ea` keeps its previous value.
- R10: A carry out of the top bit of the address width is dropped, and no flag reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe for this cycle's operands |
| base_val | input | 64 | Base register value |
| base_en | input | 1 | Base present |
| idx_val | input | 64 | Index register value |
| idx_en | input | 1 | Index present |
| scale_sel | input | 2 | Index shift amount, 0 to 3 |
| disp | input | 32 | Signed displacement |
| mode32 | input | 1 | 1 selects 32-bit address size |
| ea | output | 64 | Effective address |
| ea_vld | output | 1 | Effective address valid |

## Verification
The hardest case to reach is a 32-bit mode request that must drop a carry out of bit 31. The request also carries garbage in the upper halves of both register operands. A wrong zero-extension or a missing truncation would show up only in that combination. The stimulus sets all-ones upper words and low words close to 2^32, and adds a negative displacement. It runs this case back to back with 64-bit requests, so that a stale upper word would also be caught. Absent-operand cases carry non-zero values on the masked inputs, so that a leak of either term changes the address.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AW  = 64;
    localparam int NW  = 32;
    localparam int DW  = 32;
    localparam int SW  = 2;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_e;

    function automatic addr_t sext_disp(input logic [DW-1:0] d);
        return {{(AW-DW){d[DW-1]}}, d};
    endfunction
endpackage

// File: rtl/agu_term_gate.sv
module agu_term_gate #(
    parameter int  AW     = 64,
    parameter int  NW     = 32,
    parameter int  SW     = 2,
    parameter bit  SCALED = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] val,
    input  logic          en,
    input  logic          mode32,
    input  logic [SW-1:0] shamt,
    output logic [AW-1:0] term
);
    localparam int HW = AW - NW;

    logic [AW-1:0] narrowed;

    always_comb begin
        narrowed = mode32 ? {{HW{1'b0}}, val[NW-1:0]} : val;
    end

    generate
        if (SCALED) begin : g_scaled
            always_comb begin
                term = en ? (narrowed << shamt) : '0;
            end
            // R2: a shift by k leaves the low k bits clear
            assert_scale_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
                (shamt != '0) |-> (term[0] == 1'b0));
        end else begin : g_plain
            always_comb begin
                term = en ? narrowed : '0;
            end
        end
    endgenerate

    // R6: in narrow mode the unshifted operand never carries upper bits
    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (mode32 && !SCALED) |-> (term[AW-1:NW] == '0));
endmodule

// File: rtl/agu_adder3.sv
module agu_adder3
    import agu_pkg::*;
(
    input  addr_t         base_t,
    input  addr_t         idx_t,
    input  logic [DW-1:0] disp,
    input  logic          mode32,
    output addr_t         sum
);
    addr_t raw;

    always_comb begin
        raw = base_t + idx_t + sext_disp(disp);
        sum = mode32 ? {{(AW-NW){1'b0}}, raw[NW-1:0]} : raw;
    end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [AW-1:0] base_val,
    input  logic          base_en,
    input  logic [AW-1:0] idx_val,
    input  logic          idx_en,
    input  logic [SW-1:0] scale_sel,
    input  logic [DW-1:0] disp,
    input  logic          mode32,
    output logic [AW-1:0] ea,
    output logic          ea_vld
);
    addr_t base_t, idx_t, sum;

    agu_term_gate #(.AW(AW), .NW(NW), .SW(SW), .SCALED(1'b0)) u_base (
        .clk(clk), .rst(rst), .val(base_val), .en(base_en),
        .mode32(mode32), .shamt('0), .term(base_t)
    );

    agu_term_gate #(.AW(AW), .NW(NW), .SW(SW), .SCALED(1'b1)) u_idx (
        .clk(clk), .rst(rst), .val(idx_val), .en(idx_en),
        .mode32(mode32), .shamt(scale_sel), .term(idx_t)
    );

    agu_adder3 u_add (
        .base_t(base_t), .idx_t(idx_t), .disp(disp),
        .mode32(mode32), .sum(sum)
    );

    generate
        if (REG_OUT) begin : g_reg
            out_state_e state_q, state_d;
            addr_t      ea_q;

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    OUT_IDLE: state_d = in_vld ? OUT_LIVE : OUT_IDLE;
                    OUT_LIVE: state_d = in_vld ? OUT_LIVE : OUT_IDLE;
                    default:  state_d = OUT_IDLE;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) state_q <= OUT_IDLE;
                else     state_q <= state_d;
            end

            always_ff @(posedge clk) begin
                if (rst)         ea_q <= '0;
                else if (in_vld) ea_q <= sum;
            end

            assign ea     = ea_q;
            assign ea_vld = (state_q == OUT_LIVE);

            assert_vld_rise_R7: assert property (@(posedge clk) disable iff (rst)
                in_vld |=> ea_vld);
            assert_vld_fall_R7: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> !ea_vld);
            assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> $stable(ea));
            assert_narrow_out_R6: assert property (@(posedge clk) disable iff (rst)
                (in_vld && mode32) |=> (ea[AW-1:NW] == '0));
        end else begin : g_comb
            assign ea     = sum;
            assign ea_vld = in_vld;
        end
    endgenerate
endmodule

// File: tb/sim_agu_addr_gen.sv
module sim_agu_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [63:0] base_val = '0;
    logic        base_en = 1'b0;
    logic [63:0] idx_val = '0;
    logic        idx_en = 1'b0;
    logic [1:0]  scale_sel = '0;
    logic [31:0] disp = '0;
    logic        mode32 = 1'b0;
    logic [63:0] ea;
    logic        ea_vld;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;

    always #5 clk = ~clk;

    agu_addr_gen u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .base_val(base_val), .base_en(base_en),
        .idx_val(idx_val), .idx_en(idx_en),
        .scale_sel(scale_sel), .disp(disp), .mode32(mode32),
        .ea(ea), .ea_vld(ea_vld)
    );

    function automatic logic [63:0] model(input logic [63:0] b, input logic be,
                                          input logic [63:0] i, input logic ie,
                                          input logic [1:0] s, input logic [31:0] d,
                                          input logic m);
        logic [63:0] bt, it, dx, r;
        bt = be ? (m ? {32'h0, b[31:0]} : b) : 64'h0;
        it = ie ? (m ? {32'h0, i[31:0]} : i) : 64'h0;
        case (s)
            2'd0: it = it;
            2'd1: it = it * 2;
            2'd2: it = it * 4;
            default: it = it * 8;
        endcase
        dx = d[31] ? {32'hFFFF_FFFF, d} : {32'h0, d};
        r = bt + it + dx;
        if (m) r = {32'h0, r[31:0]};
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] b, input logic be, input logic [63:0] i,
                        input logic ie, input logic [1:0] s, input logic [31:0] d,
                        input logic m, input string tag);
        @(negedge clk);
        base_val = b; base_en = be; idx_val = i; idx_en = ie;
        scale_sel = s; disp = d; mode32 = m; in_vld = 1'b1;
        exp_q.push_back(model(b, be, i, ie, s, d, m));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 1'b0;
        base_val = 64'hDEAD_BEEF_CAFE_F00D;
        idx_val  = 64'h1234_5678_9ABC_DEF0;
        disp     = 32'h7777_0000;
    endtask

    // monitor: pops the scoreboard whenever a result is presented
    always @(negedge clk) begin
        if (!rst && ea_vld) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected valid", {63'h0, ea_vld}, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(t, ea, e);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset vld", {63'h0, ea_vld}, 64'h0);
        check("R8 reset ea", ea, 64'h0);
        rst = 1'b0;

        send(64'h0000_1000_0000_0000, 1, 64'h10, 1, 2'd0, 32'h0000_0020, 0, "R1 basic");
        send(64'h1000, 1, 64'h3, 1, 2'd1, 32'h0, 0, "R2 scale x2");
        send(64'h1000, 1, 64'h3, 1, 2'd2, 32'h0, 0, "R2 scale x4");
        send(64'h1000, 1, 64'h3, 1, 2'd3, 32'h0, 0, "R2 scale x8");
        send(64'hAAAA_0000_0000_5555, 0, 64'h40, 1, 2'd3, 32'h8, 0, "R3 base absent");
        send(64'h8000, 1, 64'hFFFF_0000_0000_1111, 0, 2'd3, 32'h4, 0, "R4 index absent");
        send(64'h1_0000_0000, 1, 64'h0, 0, 2'd0, 32'hFFFF_FFF0, 0, "R5 negative disp");
        send(64'h0, 0, 64'h0, 0, 2'd0, 32'h8000_0000, 0, "R5 disp only");
        send(64'hFFFF_FFFF_FFFF_FFF8, 1, 64'h2, 1, 2'd3, 32'h0, 0, "R10 wrap 64");
        send(64'hFFFF_FFFF_FFFF_FF00, 1, 64'hFFFF_FFFF_1000_0000, 1, 2'd1, 32'h10, 1, "R6 narrow high bits");
        send(64'hFFFF_FFFF_FFFF_FFF0, 1, 64'hFFFF_FFFF_0000_0004, 1, 2'd2, 32'hFFFF_FFFC, 1, "R6 R10 narrow wrap");
        send(64'h0000_7FFF_0000_0100, 1, 64'h20, 1, 2'd0, 32'h0, 0, "R7 back-to-back 64");
        send(64'h0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd3, 32'hFFFF_FFFF, 1, "R6 narrow disp only");
        idle();
        idle();
        check("R7 vld low after idle", {63'h0, ea_vld}, 64'h0);
        check("R9 hold after idle", ea, last_exp);
        idle();
        check("R9 hold second idle", ea, last_exp);
        send(64'h2000, 1, 64'h1, 1, 2'd3, 32'h1, 0, "R7 after gap");
        idle();
        idle();
        check("R7 scoreboard drained", {32'h0, exp_q.size()}, 64'h0);
        disable watchdog;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule